// File: doc/BRIEF.md
# Multiplexed Tablet Scan Controller

This block drives the position sampling for up to sixteen resistive-sheet tablets that share a single 10-bit converter. Each drive cycle of the tablet sheets is split into two halves by a phase input: while the phase is low the sheets carry a horizontal gradient, and while it is high they carry a vertical one. A scan begins when the phase falls. In each half the controller walks the enabled tablets in ascending index order. For each one it waits for that tablet's normalization comparator pulse, starts one conversion on that tablet's channel, and stores the result.

Results leave the block as 16-bit words on a valid/ready write port. Each word goes to a fixed slot in a buffer whose base address is an input, so software always finds tablet i at the same place. The controller raises one interrupt when a full scan (both halves) has finished. That interrupt stays set until it is acknowledged. If the next scan completes before the acknowledge arrives, the buffer is still overwritten and an overrun flag is set. Tablets whose enable bit is clear are skipped: they get no conversion and no buffer write.

Back-pressure rules: once `wr_valid` is high, it stays high and `wr_addr`/`wr_data` stay unchanged until a cycle with `wr_ready` high. A word is transferred on that cycle. While a word waits, no new conversion is started. Waiting time counts against the current half-cycle, so a long stall can turn the remaining tablets of that half into error words (see R6).

Top module: `tablet_scan_ctrl`

## Requirements
- R1: A scan starts on a falling edge of `drive_phase`. The enable mask `tab_enable` is captured at that point, and changes to it later in the scan have no effect until the next scan starts.
- R2: Within a scan, each enabled tablet produces exactly one horizontal word and then exactly one vertical word. All horizontal words come first, in ascending tablet order, followed by all vertical words in ascending tablet order.
- R3: `conv_start` is a single-cycle pulse with `conv_chan` equal to the tablet index. It is issued only for tablets enabled in the captured mask, and only after that tablet's `norm_hit` bit has been seen high in the current half. Disabled tablets get no conversion and no write.
- R4: Buffer word layout: bits 15:12 hold the tablet index, bit 11 is the error flag, bit 10 is the axis (0 horizontal, 1 vertical), and bits 9:0 hold the conversion result.
- R5: A word for tablet i is written at address `buf_base + 2*i` for the horizontal axis and `buf_base + 2*i + 1` for the vertical axis.
- R6: Some conversions do not finish in time:
  - If a tablet's conversion has not completed when its half-cycle ends, that tablet's word is written with bit 11 set and bits 9:0 zero.
  - Every enabled tablet of that half that has not yet been written is also written as such an error word.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values on the next cycle.
- R8: `scan_irq` rises once per completed scan. A scan counts as completed after its last vertical word is written and its second half has ended. `scan_irq` stays high until a cycle with `irq_ack` high.
- R9: If a scan completes while `scan_irq` is still pending, the buffer is still written and `scan_overrun` is set. `irq_ack` clears both `scan_irq` and `scan_overrun`. If a completion and an acknowledge fall in the same cycle, `scan_irq` ends up set and `scan_overrun` ends up clear.
- R10: During and right after reset, `scan_irq`, `scan_overrun`, `wr_valid` and `conv_start` are low.
- R11: A scan with an all-zero mask makes no writes and no conversions, but still raises `scan_irq` when it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drive_phase | input | 1 | Drive half indicator: 0 horizontal half, 1 vertical half |
| norm_hit | input | N_TAB | Per-tablet normalization comparator pulses for the current axis |
| tab_enable | input | N_TAB | Active-tablet mask |
| conv_start | output | 1 | Start one conversion (single-cycle pulse) |
| conv_chan | output | IDX_W | Tablet whose pickup the converter samples |
| conv_done | input | 1 | Conversion finished; `conv_data` valid this cycle |
| conv_data | input | RES_W | Conversion result |
| buf_base | input | AW | Buffer base address (even) |
| wr_valid | output | 1 | Buffer write request |
| wr_ready | input | 1 | Buffer write accepted this cycle |
| wr_addr | output | AW | Buffer write address |
| wr_data | output | WORD_W | Buffer write word |
| scan_irq | output | 1 | Scan-complete interrupt, held until acknowledged |
| irq_ack | input | 1 | Interrupt acknowledge |
| scan_overrun | output | 1 | A scan completed while the interrupt was still pending |

## Verification
The assertions rely on these properties of the inputs:
- `buf_base` is even, so address bit 0 can be compared with the axis bit of the word.
- `conv_done` arrives only in answer to a `conv_start`.
- Each half-cycle of `drive_phase` lasts long enough that a stalled write port cannot carry one half's words into the next.

The stimulus meets these conditions:
- It holds the base at an even constant.
- Its converter model answers a fixed three cycles after each start, or stays silent for a whole half to force timeouts.
- It uses 400-cycle halves, which give ample margin over sixteen tablets even with a repeating `wr_ready` stall pattern.
- It changes the mask only in the middle of a half, away from phase edges.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEEK,
    ST_NORM,
    ST_START,
    ST_CONV,
    ST_WRITE
  } seq_st_e;

  localparam int TAB_FIELD_W = 4;
endpackage

// File: rtl/tscan_phase_edge.sv
module tscan_phase_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  output logic rise,
  output logic fall
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase;
  end

  assign rise = phase & ~phase_q;
  assign fall = ~phase & phase_q;
endmodule

// File: rtl/tscan_irq.sv
module tscan_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_done,
  input  logic irq_ack,
  output logic scan_irq,
  output logic scan_overrun
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_irq     <= 1'b0;
      scan_overrun <= 1'b0;
    end else if (scan_done) begin
      scan_irq     <= 1'b1;
      scan_overrun <= irq_ack ? 1'b0 : (scan_overrun | scan_irq);
    end else if (irq_ack) begin
      scan_irq     <= 1'b0;
      scan_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/tscan_seq.sv
module tscan_seq
  import tscan_pkg::*;
#(
  parameter int N_TAB  = 16,
  parameter int RES_W  = 10,
  parameter int AW     = 16,
  parameter int IDX_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_half_end,
  input  logic              y_half_end,
  input  logic [N_TAB-1:0]  norm_hit,
  input  logic [N_TAB-1:0]  tab_enable,
  output logic              conv_start,
  output logic [IDX_W-1:0]  conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic [AW-1:0]     buf_base,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [N_TAB-1:0]  scan_mask,
  output logic              scan_done
);
  localparam int CNT_W = IDX_W + 1;

  seq_st_e          st_q;
  logic [CNT_W-1:0] idx_q;
  logic             axis_q;
  logic             late_q;
  logic             err_q;
  logic [RES_W-1:0] res_q;
  logic [N_TAB-1:0] mask_q;

  logic [IDX_W-1:0] sel;
  logic             idx_end;
  logic             half_end;
  logic             late_now;

  assign sel      = idx_q[IDX_W-1:0];
  assign idx_end  = (idx_q == CNT_W'(N_TAB));
  assign half_end = axis_q ? y_half_end : x_half_end;
  assign late_now = late_q | half_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      axis_q <= 1'b0;
      late_q <= 1'b0;
      err_q  <= 1'b0;
      res_q  <= '0;
      mask_q <= '0;
    end else begin
      late_q <= late_now;
      unique case (st_q)
        ST_IDLE: begin
          if (y_half_end) begin
            mask_q <= tab_enable;
            idx_q  <= '0;
            axis_q <= 1'b0;
            late_q <= 1'b0;
            st_q   <= ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (idx_end) begin
            if (late_now) begin
              idx_q  <= '0;
              late_q <= 1'b0;
              axis_q <= ~axis_q;
              if (axis_q) mask_q <= tab_enable;
            end
          end else if (mask_q[sel]) begin
            st_q <= ST_NORM;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        ST_NORM: begin
          if (late_now) begin
            err_q <= 1'b1;
            res_q <= '0;
            st_q  <= ST_WRITE;
          end else if (norm_hit[sel]) begin
            st_q <= ST_START;
          end
        end
        ST_START: st_q <= ST_CONV;
        ST_CONV: begin
          if (conv_done) begin
            err_q <= 1'b0;
            res_q <= conv_data;
            st_q  <= ST_WRITE;
          end else if (late_now) begin
            err_q <= 1'b1;
            res_q <= '0;
            st_q  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (wr_ready) begin
            idx_q <= idx_q + CNT_W'(1);
            st_q  <= ST_SEEK;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_done  = (st_q == ST_SEEK) && idx_end && late_now && axis_q;
  assign conv_start = (st_q == ST_START);
  assign conv_chan  = sel;
  assign wr_valid   = (st_q == ST_WRITE);
  assign wr_addr    = buf_base + AW'({sel, axis_q});
  assign wr_data    = {TAB_FIELD_W'(sel), err_q, axis_q, res_q};
  assign scan_mask  = mask_q;
endmodule

// File: rtl/tablet_scan_ctrl.sv
module tablet_scan_ctrl #(
  parameter int N_TAB = 16,
  parameter int RES_W = 10,
  parameter int AW    = 16,
  localparam int IDX_W  = (N_TAB > 1) ? $clog2(N_TAB) : 1,
  localparam int WORD_W = tscan_pkg::TAB_FIELD_W + 2 + RES_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_phase,
  input  logic [N_TAB-1:0]  norm_hit,
  input  logic [N_TAB-1:0]  tab_enable,
  output logic              conv_start,
  output logic [IDX_W-1:0]  conv_chan,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic [AW-1:0]     buf_base,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              scan_irq,
  input  logic              irq_ack,
  output logic              scan_overrun
);
  logic             ph_rise;
  logic             ph_fall;
  logic             scan_done;
  logic [N_TAB-1:0] scan_mask;

  tscan_phase_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (drive_phase),
    .rise  (ph_rise),
    .fall  (ph_fall)
  );

  tscan_seq #(
    .N_TAB  (N_TAB),
    .RES_W  (RES_W),
    .AW     (AW),
    .IDX_W  (IDX_W),
    .WORD_W (WORD_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .x_half_end (ph_rise),
    .y_half_end (ph_fall),
    .norm_hit   (norm_hit),
    .tab_enable (tab_enable),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .buf_base   (buf_base),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .scan_mask  (scan_mask),
    .scan_done  (scan_done)
  );

  tscan_irq u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .scan_done    (scan_done),
    .irq_ack      (irq_ack),
    .scan_irq     (scan_irq),
    .scan_overrun (scan_overrun)
  );
endmodule

// File: rtl/tscan_chk.sv
module tscan_chk #(
  parameter int N_TAB  = 16,
  parameter int RES_W  = 10,
  parameter int AW     = 16,
  parameter int IDX_W  = 4,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [AW-1:0]     wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              conv_start,
  input logic [IDX_W-1:0]  conv_chan,
  input logic [N_TAB-1:0]  scan_mask,
  input logic              scan_irq,
  input logic              irq_ack,
  input logic              scan_overrun,
  input logic [AW-1:0]     buf_base
);
  localparam int AXIS_BIT = RES_W;
  localparam int ERR_BIT  = RES_W + 1;

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r3_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> scan_mask[conv_chan]);

  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r8_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq && !irq_ack |=> scan_irq);

  a_r9_overrun_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
    scan_overrun |-> scan_irq);

  a_r6_error_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_data[ERR_BIT] |-> wr_data[RES_W-1:0] == '0);

  a_r5_slot_parity: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !buf_base[0] |-> wr_addr[0] == wr_data[AXIS_BIT]);
endmodule

bind tablet_scan_ctrl tscan_chk #(
  .N_TAB  (N_TAB),
  .RES_W  (RES_W),
  .AW     (AW),
  .IDX_W  (IDX_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .conv_start   (conv_start),
  .conv_chan    (conv_chan),
  .scan_mask    (scan_mask),
  .scan_irq     (scan_irq),
  .irq_ack      (irq_ack),
  .scan_overrun (scan_overrun),
  .buf_base     (buf_base)
);

// File: tb/tablet_scan_ctrl_tb.sv
`timescale 1ns/1ps
module tablet_scan_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drive_phase = 1'b1;
  logic [15:0] norm_hit = '0;
  logic [15:0] tab_enable = '0;
  logic        conv_start;
  logic [3:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_data = '0;
  logic [15:0] buf_base = 16'h0400;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        scan_irq;
  logic        irq_ack = 1'b0;
  logic        scan_overrun;

  always #2.5 clk = ~clk;

  tablet_scan_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .drive_phase(drive_phase), .norm_hit(norm_hit),
    .tab_enable(tab_enable), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_data(conv_data), .buf_base(buf_base),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .scan_irq(scan_irq), .irq_ack(irq_ack), .scan_overrun(scan_overrun)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit run = 0;
  bit done = 0;
  int cyc = 0;
  int scan_no = 0;
  int wr_cnt = 0;
  int irq_edges = 0;
  bit irq_prev = 0;
  bit conv_dead = 0;
  int cd_cnt = 0;
  logic [9:0]  pend = '0;
  logic [15:0] cur_mask = '0;
  logic [31:0] expq[$];
  bit          prev_hold = 0;
  logic [15:0] prev_addr = '0;
  logic [15:0] prev_data = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] dataf(input int ch, input int ax, input int sc);
    return 10'((ch * 61 + ax * 300 + sc * 7) % 1024);
  endfunction

  task automatic push_half(input int ax, input bit err);
    for (int i = 0; i < 16; i++) begin
      if (cur_mask[i]) begin
        logic [15:0] a;
        logic [15:0] d;
        a = buf_base + 16'(2 * i + ax);
        d = {4'(i), err, ax[0], err ? 10'd0 : dataf(i, ax, scan_no)};
        expq.push_back({a, d});
      end
    end
  endtask

  // reference model and responders, evaluated every clock away from the edge
  always @(negedge clk) begin
    if (run) begin
      cyc++;
      wr_ready = ((cyc % 5) != 3) && ((cyc % 7) != 0);
      norm_hit = ((cyc % 6) == 0) ? 16'hFFFF : 16'h0000;
      if (conv_done) conv_done = 1'b0;
      if (cd_cnt > 0) begin
        cd_cnt--;
        if (cd_cnt == 0) begin
          conv_done = 1'b1;
          conv_data = pend;
        end
      end
      if (conv_start) begin
        chk(cur_mask[conv_chan] == 1'b1, "R3 start only for enabled tablet", conv_chan, cur_mask);
        if (!conv_dead) begin
          cd_cnt = 3;
          pend = dataf(int'(conv_chan), int'(drive_phase), scan_no);
        end
      end
      if (prev_hold)
        chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data, "R7 hold under stall",
            {wr_valid, wr_addr, wr_data}, {1'b1, prev_addr, prev_data});
      if (wr_valid && wr_ready) begin
        wr_cnt++;
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected write", {wr_addr, wr_data}, 0);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk({wr_addr, wr_data} == e, "R2 R4 R5 R6 buffer word", {wr_addr, wr_data}, e);
        end
      end
      prev_hold = wr_valid && !wr_ready;
      prev_addr = wr_addr;
      prev_data = wr_data;
      if (scan_irq && !irq_prev) irq_edges++;
      irq_prev = scan_irq;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ack_irq();
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    chk(scan_irq == 1'b0, "R8 irq cleared by ack", scan_irq, 0);
  endtask

  logic [15:0] masks [1:6];

  initial begin
    masks[1] = 16'hFFFF;
    masks[2] = 16'hA5C3;
    masks[3] = 16'h0000;
    masks[4] = 16'h8421;
    masks[5] = 16'h00F0;
    masks[6] = 16'h1248;
    step(4);
    chk(scan_irq == 0 && scan_overrun == 0, "R10 irq flags in reset", {scan_irq, scan_overrun}, 0);
    chk(wr_valid == 0 && conv_start == 0, "R10 no request in reset", {wr_valid, conv_start}, 0);
    rst_n = 1'b1;
    run = 1'b1;
    tab_enable = masks[1];
    step(20);
    chk(scan_irq == 0 && scan_overrun == 0, "R10 irq flags after reset", {scan_irq, scan_overrun}, 0);
    chk(wr_valid == 0, "R10 no write before first scan", wr_valid, 0);
    for (int s = 1; s <= 6; s++) begin
      drive_phase = 1'b0;
      conv_dead = 0;
      scan_no = s;
      cur_mask = tab_enable;
      push_half(0, 0);
      step(200);
      if (s == 1) begin
        chk(scan_irq == 0, "R8 no irq before first completion", scan_irq, 0);
      end else begin
        chk(scan_irq == 1, (s == 4) ? "R11 irq after empty scan" : "R8 irq after scan", scan_irq, 1);
        chk(scan_overrun == 0, "R9 no overrun when acked in time", scan_overrun, 0);
        if (s == 3)
          chk(wr_cnt == 48, "R1 scan used mask captured at start", wr_cnt, 48);
        if (s != 6) ack_irq();
      end
      if (s == 2) tab_enable = 16'h0001;
      step(200);
      drive_phase = 1'b1;
      if (s == 4) begin
        conv_dead = 1;
        push_half(1, 1);
      end else begin
        push_half(1, 0);
      end
      step(200);
      chk(scan_irq == (s == 6), "R8 irq state mid second half", scan_irq, (s == 6));
      tab_enable = (s < 6) ? masks[s+1] : 16'h0000;
      step(200);
    end
    drive_phase = 1'b0;
    conv_dead = 0;
    scan_no = 7;
    cur_mask = tab_enable;
    step(200);
    chk(scan_irq == 1, "R8 irq pending at overrun", scan_irq, 1);
    chk(scan_overrun == 1, "R9 overrun set on unacked completion", scan_overrun, 1);
    irq_ack = 1'b1;
    step(1);
    irq_ack = 1'b0;
    chk(scan_irq == 0 && scan_overrun == 0, "R9 ack clears irq and overrun",
        {scan_irq, scan_overrun}, 0);
    chk(expq.size() == 0, "R2 all expected words written", expq.size(), 0);
    chk(irq_edges == 5, "R8 one irq rise per acked scan", irq_edges, 5);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule